// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is an 8-bit up-counter that runs from a divided peripheral clock. It has two uses. In watchdog mode, the counter wrapping from 0xFF to 0x00 sends a one-cycle reset request to the chip's reset logic. A type bit travels with that request. In interval mode, the same wrap sets a flag, and that flag drives an interrupt line until software clears it.

Software sees two 16-bit write targets: the count and the control word. Each has its own strobe. A write lands only when the upper byte carries the key for that target. Any other write is dropped. This means a stray store cannot easily reload or reconfigure the timer. The current count and control word are driven out continuously, so the surrounding register file can read them back.

Top module: `wdt_keyed`

## Requirements
- R1: A count write (`wr_cnt`) loads `wdata[7:0]` into the counter only when `wdata[15:8]` is 0x5A. With any other upper byte, the counter is left unchanged.
- R2: A control write (`wr_ctl`) is accepted only when `wdata[15:8]` is 0xA5. The control fields are: bit 7 = run enable, bit 6 = mode (1 = watchdog, 0 = interval), bit 5 = reset type, bits 4 and 3 = flags, bits 2:0 = divider code. A write with another key leaves `ctl_q` unchanged.
- R3: While bit 7 is 0, the counter holds its value and the prescaler is held at zero. After re-enabling, the first step comes one full divider period later.
- R4: The counter advances once every N peripheral clock cycles. Divider codes 0 to 7 give N = 1, 4, 16, 32, 64, 256, 1024 and 4096.
- R5: In watchdog mode, a wrap from 0xFF to 0x00 sets flag bit 4 and raises `rst_req` for exactly one cycle. This happens on the same edge as the wrap.
- R6: While `rst_req` is high, `rst_kind` equals the value that bit 5 had when the wrap occurred.
- R7: In interval mode, a wrap sets flag bit 3 and does not raise `rst_req`. `irq` is high while bit 3 is set.
- R8: A flag is cleared only by an accepted control write with 0 in that flag's bit. Writing 1 to a flag bit leaves the flag as it was. A wrap that happens on the same edge as a clearing write wins, and the flag stays set.
- R9: After reset, the count is 0x00, the control word is 0x00, and `rst_req`, `rst_kind` and `irq` are low.
- R10: Without an accepted count write, the counter changes by at most +1 per cycle, wrapping modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cnt | input | 1 | Write strobe for the count |
| wr_ctl | input | 1 | Write strobe for the control word |
| wdata | input | 16 | Write data: key in bits 15:8, value in bits 7:0 |
| cnt_q | output | 8 | Current count |
| ctl_q | output | 8 | Current control word, including both flags |
| rst_req | output | 1 | One-cycle reset request on watchdog wrap |
| rst_kind | output | 1 | Reset type that accompanies `rst_req` |
| irq | output | 1 | Interval interrupt, high while the interval flag is set |

## Verification
The assertions check these rules on every cycle:
- The counter and control word change only after writes that carry the correct key.
- A disabled counter stays still, and an enabled one never steps by more than one.
- A reset request lasts one cycle and always comes with the watchdog flag set.
- The interval flag only rises right after the count was 0xFF.
- A flag only falls after a keyed write of 0 to it.

Some behaviour needs the directed scenarios to show it:
- The exact divider period for all eight codes.
- That the prescaler restarts from zero after re-enabling.
- That the reset type is captured correctly.
- That a wrap beats a clearing write on the same edge.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int DIV_W = 12;

  typedef struct packed {
    logic       run;
    logic       wd_mode;
    logic       rst_sel;
    logic       wd_flag;
    logic       iv_flag;
    logic [2:0] cks;
  } ctl_t;

  // terminal count of the prescaler for each divider code
  function automatic logic [DIV_W-1:0] div_limit(input logic [2:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      3'd0:    r = DIV_W'(0);
      3'd1:    r = DIV_W'(3);
      3'd2:    r = DIV_W'(15);
      3'd3:    r = DIV_W'(31);
      3'd4:    r = DIV_W'(63);
      3'd5:    r = DIV_W'(255);
      3'd6:    r = DIV_W'(1023);
      default: r = DIV_W'(4095);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] cks,
  output logic       tick
);
  logic [DIV_W-1:0] pcnt;

  assign tick = run && (pcnt >= div_limit(cks));

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // a load on the same edge suppresses the step and the wrap
  assign wrap = tick && !load && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       wrap,
  output ctl_t       ctl,
  output logic       rst_req,
  output logic       rst_kind
);
  ctl_t wv;
  assign wv = ctl_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      rst_req  <= 1'b0;
      rst_kind <= 1'b0;
    end else begin
      if (wr) begin
        ctl.run     <= wv.run;
        ctl.wd_mode <= wv.wd_mode;
        ctl.rst_sel <= wv.rst_sel;
        ctl.cks     <= wv.cks;
        ctl.wd_flag <= ctl.wd_flag & wv.wd_flag;
        ctl.iv_flag <= ctl.iv_flag & wv.iv_flag;
      end
      // wrap sets the flag even against a clearing write
      if (wrap &&  ctl.wd_mode) ctl.wd_flag <= 1'b1;
      if (wrap && !ctl.wd_mode) ctl.iv_flag <= 1'b1;
      rst_req <= wrap && ctl.wd_mode;
      if (wrap && ctl.wd_mode) rst_kind <= ctl.rst_sel;
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CTL_KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cnt,
  input  logic             wr_ctl,
  input  logic [15:0]      wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [7:0]       ctl_q,
  output logic             rst_req,
  output logic             rst_kind,
  output logic             irq
);
  logic cnt_ok, ctl_ok, tick, wrap;
  ctl_t ctl;

  assign cnt_ok = wr_cnt && (wdata[15:8] == CNT_KEY);
  assign ctl_ok = wr_ctl && (wdata[15:8] == CTL_KEY);

  wdt_prescale u_pre (
    .clk(clk), .rst(rst), .run(ctl.run), .cks(ctl.cks), .tick(tick)
  );

  wdt_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_ok),
    .load_val(wdata[CNT_W-1:0]), .cnt(cnt_q), .wrap(wrap)
  );

  wdt_ctrl u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_ok), .wdata(wdata[7:0]), .wrap(wrap),
    .ctl(ctl), .rst_req(rst_req), .rst_kind(rst_kind)
  );

  assign ctl_q = ctl;
  assign irq   = ctl.iv_flag;
endmodule

// File: rtl/wdt_keyed_chk.sv
`timescale 1ns/1ps
module wdt_keyed_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_cnt,
  input logic        wr_ctl,
  input logic [15:0] wdata,
  input logic [7:0]  cnt_q,
  input logic [7:0]  ctl_q,
  input logic        rst_req,
  input logic        irq
);
  logic ctl_key;
  assign ctl_key = wr_ctl && (wdata[15:8] == 8'hA5);

  p_bad_key_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && wdata[15:8] != 8'h5A && !ctl_q[7]) |=> $stable(cnt_q));

  p_ctl_write_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_key |=> (ctl_q[7:5] == $past(wdata[7:5]) && ctl_q[2:0] == $past(wdata[2:0])));

  p_ctl_nokey_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_key && !ctl_q[7]) |=> $stable(ctl_q));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[7] && !wr_cnt) |=> $stable(cnt_q));

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_req_flag_r5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ctl_q[4]);

  p_iflag_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q[3]) |-> ($past(cnt_q) == 8'hFF && cnt_q == 8'h00));

  p_irq_noreq_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !rst_req);

  p_wclear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q[4]) |-> $past(ctl_key && !wdata[4]));

  p_iclear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q[3]) |-> $past(ctl_key && !wdata[3]));

  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
  .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wdata(wdata),
  .cnt_q(cnt_q), .ctl_q(ctl_q), .rst_req(rst_req), .irq(irq)
);

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_cnt = 1'b0, wr_ctl = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  cnt_q, ctl_q;
  logic        rst_req, rst_kind, irq;
  int          errs = 0, checks = 0;

  always #10 clk = ~clk;

  wdt_keyed dut (
    .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wdata(wdata),
    .cnt_q(cnt_q), .ctl_q(ctl_q), .rst_req(rst_req), .rst_kind(rst_kind), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit to_ctl, input logic [15:0] d);
    wdata = d;
    if (to_ctl) wr_ctl = 1'b1; else wr_cnt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_ctl = 1'b0;
    wr_cnt = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 count", 16'(cnt_q), 16'h00);
    chk("R9 ctl", 16'(ctl_q), 16'h00);
    chk("R9 outputs", {13'd0, rst_req, rst_kind, irq}, 16'h0);
  endtask

  task automatic t_keys;
    wr(0, 16'h5A37);
    chk("R1 keyed load", 16'(cnt_q), 16'h37);
    wr(0, 16'hA599);
    chk("R1 wrong key", 16'(cnt_q), 16'h37);
    wr(1, 16'h5AE5);
    chk("R2 wrong key", 16'(ctl_q), 16'h00);
    chk("R2 count untouched", 16'(cnt_q), 16'h37);
    wr(1, 16'hA565);
    chk("R2 keyed write", 16'(ctl_q), 16'h65);
    wr(1, 16'hA500);
  endtask

  task automatic t_hold;
    wr(0, 16'h5A40);
    wr(1, 16'hA581);
    edges(6);
    chk("R3 running /4", 16'(cnt_q), 16'h41);
    wr(1, 16'hA501);
    edges(5);
    chk("R3 held", 16'(cnt_q), 16'h41);
    wr(1, 16'hA581);
    edges(3);
    chk("R3 prescaler restarted", 16'(cnt_q), 16'h41);
    edges(1);
    chk("R3 first step", 16'(cnt_q), 16'h42);
    wr(1, 16'hA500);
  endtask

  task automatic t_ratio;
    for (int c = 0; c < 8; c++) begin
      int r;
      case (c)
        0: r = 1;    1: r = 4;    2: r = 16;   3: r = 32;
        4: r = 64;   5: r = 256;  6: r = 1024; default: r = 4096;
      endcase
      wr(0, 16'h5A10);
      wr(1, 16'hA580 | 16'(c));
      edges(r - 1);
      chk($sformatf("R4 code %0d before", c), 16'(cnt_q), 16'h10);
      edges(1);
      chk($sformatf("R4 code %0d step", c), 16'(cnt_q), 16'h11);
      wr(1, 16'hA500);
    end
  endtask

  task automatic t_watchdog;
    wr(0, 16'h5AFD);
    wr(1, 16'hA5E0);
    edges(2);
    chk("R5 no early req", 16'(rst_req), 16'h0);
    edges(1);
    chk("R5 wrap count", 16'(cnt_q), 16'h00);
    chk("R5 req high", 16'(rst_req), 16'h1);
    chk("R6 kind", 16'(rst_kind), 16'h1);
    chk("R5 flag", 16'(ctl_q[4]), 16'h1);
    chk("R7 no irq in wd mode", 16'(irq), 16'h0);
    edges(1);
    chk("R5 one cycle", 16'(rst_req), 16'h0);
    wr(1, 16'hA510);
    chk("R8 write 1 keeps", 16'(ctl_q[4]), 16'h1);
    wr(1, 16'h5A00);
    chk("R8 bad key keeps", 16'(ctl_q[4]), 16'h1);
    wr(1, 16'hA500);
    chk("R8 cleared", 16'(ctl_q[4]), 16'h0);
    // second wrap with type 0
    wr(0, 16'h5AFF);
    wr(1, 16'hA5C0);
    edges(1);
    chk("R6 kind 0 req", 16'(rst_req), 16'h1);
    chk("R6 kind 0", 16'(rst_kind), 16'h0);
    wr(1, 16'hA500);
  endtask

  task automatic t_interval;
    wr(0, 16'h5AFE);
    wr(1, 16'hA580);
    edges(2);
    chk("R7 flag", 16'(ctl_q[3]), 16'h1);
    chk("R7 irq", 16'(irq), 16'h1);
    chk("R7 no req", 16'(rst_req), 16'h0);
    edges(1);
    chk("R7 no req later", 16'(rst_req), 16'h0);
    wr(0, 16'h5A05);
    chk("R8 count write keeps irq", 16'(irq), 16'h1);
    wr(1, 16'hA500);
    chk("R8 irq cleared", 16'(irq), 16'h0);
    // wrap against a clearing write on the same edge
    wr(0, 16'h5AFE);
    wr(1, 16'hA580);
    edges(1);
    wr(1, 16'hA580);
    chk("R8 wrap wins clear", 16'(ctl_q[3]), 16'h1);
    wr(1, 16'hA500);
    chk("R8 cleared after", 16'(ctl_q[3]), 16'h0);
  endtask

  task automatic t_step;
    wr(0, 16'h5A20);
    wr(1, 16'hA580);
    edges(5);
    chk("R10 single steps", 16'(cnt_q), 16'h25);
    wr(1, 16'hA500);
  endtask

  initial begin
    edges(3);
    rst = 1'b0;
    edges(1);
    t_reset();
    t_keys();
    t_hold();
    t_ratio();
    t_watchdog();
    t_interval();
    t_step();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule